// File: doc/BRIEF.md
# Sign-Magnitude Adder-Subtractor

This block adds or subtracts two signed integers held in sign-magnitude form. Each operand is N bits wide: the most significant bit is the sign (1 means negative) and the lower N-1 bits are the magnitude. Internally, each operand is turned into a complement code that keeps its sign bit: a negative value has its magnitude bits inverted and incremented. In subtract mode the sign of the second operand is flipped first. The two codes then go through a plain unsigned ripple adder, and the sum is turned back into sign-magnitude by the same invert-and-increment rule.

Operands enter on a valid/ready stream and results leave on another. A transfer happens on any rising clock edge where valid and ready are both high. The block holds one result register. It accepts a new operation whenever that register is empty or is being drained in the same cycle, so in_ready equals `!out_valid || out_ready`. A result that is not taken stays unchanged at the output until out_ready rises. The default width is N = 5, which gives values from -15 to +15.

Top module: `sm_addsub_stream`

## Requirements
- R1: With in_sub = 0 and out_ovf = 0, out_sum is the sign-magnitude code of A + B. Sign is bit N-1 (1 = negative) and the magnitude is in bits N-2..0.
- R2: With in_sub = 1 and out_ovf = 0, out_sum is the sign-magnitude code of A - B.
- R3: An operand whose magnitude bits are all zero counts as zero, whatever its sign bit.
- R4: A zero result always comes out with its sign bit at 0. Negative zero is never produced.
- R5: out_ovf is 1 exactly when the true result lies outside -(2^(N-1)-1) .. +(2^(N-1)-1). This covers complement overflow, detected where the carry into the top adder bit differs from the carry out of it, and also a sum equal to the most negative complement code, which sign-magnitude cannot hold.
- R6: An operation accepted at one rising edge is presented with out_valid = 1 directly after that edge.
- R7: While out_valid = 1 and out_ready = 0, in_ready is 0, and out_valid, out_sum and out_ovf hold their values into the next cycle.
- R8: During reset, out_valid is 0 and in_ready is 1.
- R9: With in_valid = 0 and no pending result, out_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered on in_a, in_b, in_sub |
| in_ready | output | 1 | Block can take an operation this cycle |
| in_a | input | N | First operand, sign-magnitude |
| in_b | input | N | Second operand, sign-magnitude |
| in_sub | input | 1 | 0 = add, 1 = subtract B from A |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_sum | output | N | Result, sign-magnitude |
| out_ovf | output | 1 | Result out of representable range |

## Verification
The assertions assume that operand and mode inputs carry known values whenever in_valid is high. They also assume out_ready may change freely from cycle to cycle, because the hold property has to survive any stall pattern. The stimulus changes inputs only on falling edges. It keeps each offered operation steady until it is accepted, and it drives out_ready from an irregular stall pattern so that stalls of one and of several cycles both occur. Every operand pair, including both negative-zero codes and the extreme magnitudes, is offered in both modes.

// File: rtl/sm_arith_pkg.sv
package sm_arith_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } sm_op_e;

  localparam int SM_DEFAULT_WIDTH = 5;
endpackage

// File: rtl/sm_to_twos.sv
module sm_to_twos #(
  parameter int N = 5
) (
  input  logic [N-1:0] sm_in,
  output logic [N-1:0] tc_out
);
  localparam int MW = N - 1;

  logic [MW-1:0] mag;
  logic [MW-1:0] inv_inc;
  logic          is_neg;

  assign mag     = sm_in[MW-1:0];
  assign inv_inc = (~mag) + MW'(1);
  assign is_neg  = sm_in[N-1] && (|mag);

  always_comb begin
    if (is_neg) tc_out = {1'b1, inv_inc};
    else        tc_out = {1'b0, mag};
  end
endmodule

// File: rtl/sm_ripple_adder.sv
module sm_ripple_adder #(
  parameter int W = 5
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         carry_into_msb,
  output logic         carry_out
);
  logic [W:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic half_s;
    logic half_c;
    assign half_s     = x[i] ^ y[i];
    assign half_c     = x[i] & y[i];
    assign sum[i]     = half_s ^ chain[i];
    assign chain[i+1] = half_c | (half_s & chain[i]);
  end

  assign carry_into_msb = chain[W-1];
  assign carry_out      = chain[W];
endmodule

// File: rtl/sm_from_twos.sv
module sm_from_twos #(
  parameter int N = 5
) (
  input  logic [N-1:0] tc_in,
  output logic [N-1:0] sm_out
);
  localparam int MW = N - 1;

  logic [MW-1:0] low;
  logic [MW-1:0] mag;
  logic          neg;

  assign low = tc_in[MW-1:0];
  assign neg = tc_in[N-1];

  always_comb begin
    if (neg) mag = (~low) + MW'(1);
    else     mag = low;
  end

  // sign is cleared whenever the magnitude is zero
  assign sm_out = {neg && (|mag), mag};
endmodule

// File: rtl/sm_addsub_stream.sv
module sm_addsub_stream
  import sm_arith_pkg::*;
#(
  parameter int N = SM_DEFAULT_WIDTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_a,
  input  logic [N-1:0] in_b,
  input  logic         in_sub,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] out_sum,
  output logic         out_ovf
);
  localparam int MW = N - 1;
  localparam logic [N-1:0] MOST_NEG = {1'b1, {MW{1'b0}}};

  logic [N-1:0] b_eff;
  logic [N-1:0] ta;
  logic [N-1:0] tb;
  logic [N-1:0] tsum;
  logic         c_msb_in;
  logic         c_msb_out;
  logic         ovf_c;
  logic [N-1:0] res_c;
  logic         take;

  // subtraction: negate B by flipping its sign before conversion
  assign b_eff = {in_b[N-1] ^ (sm_op_e'(in_sub) == OP_SUB), in_b[MW-1:0]};

  sm_to_twos #(.N(N)) u_conv_a (.sm_in(in_a),  .tc_out(ta));
  sm_to_twos #(.N(N)) u_conv_b (.sm_in(b_eff), .tc_out(tb));

  sm_ripple_adder #(.W(N)) u_add (
    .x              (ta),
    .y              (tb),
    .cin            (1'b0),
    .sum            (tsum),
    .carry_into_msb (c_msb_in),
    .carry_out      (c_msb_out)
  );

  sm_from_twos #(.N(N)) u_back (.tc_in(tsum), .sm_out(res_c));

  assign ovf_c = (c_msb_in ^ c_msb_out) | (tsum == MOST_NEG);

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
      out_ovf   <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_sum   <= res_c;
      out_ovf   <= ovf_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_a[MW-1:0] == '0)) |-> (ta == '0));  // R3

  AST_MIXED_SIGN_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (ta[N-1] != tb[N-1])) |-> !ovf_c);  // R5

  AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);  // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) && $stable(out_ovf)));  // R7

  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !out_valid) |=> !out_valid);  // R9

  AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_sum[MW-1:0] == '0)) |-> !out_sum[N-1]);  // R4
endmodule

// File: tb/sm_addsub_stream_tb.sv
`timescale 1ns/1ps
module sm_addsub_stream_tb;
  localparam int N    = 5;
  localparam int MW   = N - 1;
  localparam int MAXM = (1 << MW) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [N-1:0] in_a = '0;
  logic [N-1:0] in_b = '0;
  logic         in_sub = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [N-1:0] out_sum;
  logic         out_ovf;

  always #2 clk = ~clk;

  sm_addsub_stream #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_sub(in_sub),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum), .out_ovf(out_ovf)
  );

  typedef struct {
    logic [N-1:0] sum;
    logic         ovf;
    logic [N-1:0] a;
    logic [N-1:0] b;
    logic         sub;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  bit   lat_pending = 0;
  bit   done = 0;
  bit   prev_stall = 0;
  logic [N-1:0] prev_sum;
  logic         prev_ovf;

  function automatic int smval(logic [N-1:0] v);
    int m;
    m = int'(v[MW-1:0]);
    return v[N-1] ? -m : m;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(logic [N-1:0] a, logic [N-1:0] b, logic sub);
    exp_t e;
    int r;
    r = smval(a) + (sub ? -smval(b) : smval(b));
    e.a = a; e.b = b; e.sub = sub;
    e.ovf = (r > MAXM) || (r < -MAXM);
    if (r < 0) e.sum = {1'b1, MW'(-r)};
    else       e.sum = {1'b0, MW'(r)};
    if ((a[N-1] && a[MW-1:0] == '0) || (b[N-1] && b[MW-1:0] == '0)) e.tag = "R3";
    else if (r == 0) e.tag = "R4";
    else e.tag = sub ? "R2" : "R1";
    q.push_back(e);
  endtask

  task automatic send(logic [N-1:0] a, logic [N-1:0] b, logic sub);
    @(negedge clk);
    if (lat_pending) begin
      check(out_valid == 1'b1, "R6", "out_valid after accept", int'(out_valid), 1);
      lat_pending = 0;
    end
    in_valid = 1'b1; in_a = a; in_b = b; in_sub = sub;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    push(a, b, sub);
    lat_pending = 1;
  endtask

  // monitor: drives back-pressure and scores results
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = !(((cyc % 7) == 3) || ((cyc % 13) == 6) || ((cyc % 13) == 7));
      #1;
      if (rst_n) begin
        if (prev_stall) begin
          check(out_valid == 1'b1, "R7", "valid held", int'(out_valid), 1);
          check(out_sum == prev_sum && out_ovf == prev_ovf, "R7", "result held",
                int'({out_ovf, out_sum}), int'({prev_ovf, prev_sum}));
        end
        prev_stall = out_valid && !out_ready;
        if (prev_stall) begin
          prev_sum = out_sum;
          prev_ovf = out_ovf;
          check(in_ready == 1'b0, "R7", "in_ready in stall", int'(in_ready), 0);
        end
        if (out_valid && out_ready) begin
          if (q.size() == 0) begin
            check(1'b0, "R6", "unexpected result", int'(out_sum), -1);
          end else begin
            exp_t e;
            e = q.pop_front();
            check(out_ovf == e.ovf, "R5", "overflow flag", int'(out_ovf), int'(e.ovf));
            if (!e.ovf)
              check(out_sum == e.sum, e.tag, "sum", int'(out_sum), int'(e.sum));
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R8", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R9", "idle out_valid", int'(out_valid), 0);
    end
    // directed corners
    send(5'b10000, 5'b00011, 1'b0); // R3: -0 + 3 = 3
    send(5'b00101, 5'b00101, 1'b1); // R4: 5 - 5 = +0
    send(5'b10111, 5'b00111, 1'b0); // R4: -7 + 7 = +0
    send(5'b11000, 5'b11000, 1'b0); // R5: -8 + -8 = -16 overflow
    send(5'b01111, 5'b11111, 1'b1); // R5: 15 - (-15) overflow
    send(5'b01000, 5'b00111, 1'b0); // R1: 8 + 7 = 15 no overflow
    send(5'b10011, 5'b01001, 1'b1); // R2: -3 - 9 = -12
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < (1 << N); a++)
        for (int b = 0; b < (1 << N); b++)
          send(N'(a), N'(b), s[0]);
    @(negedge clk);
    if (lat_pending) begin
      check(out_valid == 1'b1, "R6", "out_valid after accept", int'(out_valid), 1);
      lat_pending = 0;
    end
    in_valid = 1'b0;
    for (int w = 0; w < 200 && q.size() != 0; w++) @(negedge clk);
    check(q.size() == 0, "R6", "results drained", q.size(), 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule